// File: doc/BRIEF.md
# GPIO Interrupt Sense Unit

This unit turns eight already-synchronized GPIO input levels into a single interrupt request. Each pin carries its own trigger setup: it can be sensed on a level or on an edge, the active level or edge direction is selectable, and an edge-sensed pin can be told to fire on both transitions. Every pin has a raw pending bit, a per-pin enable and a masked pending bit. One output is driven while any masked bit is set.

Edge events are captured in a sticky bit. It stays set until software writes a one to that pin's position in the acknowledge register. Level events are not stored: the raw bit follows the input in the same cycle and drops when the input leaves its active level. Software reaches the configuration and status through a simple byte-wide register port. Writes take effect on the clock edge and reads are combinational.

The previous pin sample is reset to zero. The unit assumes that pins are low while reset is asserted.

Top module: `gpio_irq_sense`

## Requirements
- R1: After reset, the registers at 0x404, 0x408, 0x40C, 0x410, 0x414 and 0x418 all read 0, and `irq_out` is low.
- R2: The sense-mode register at 0x404 is read/write. Bit n = 1 makes pin n level-sensed and bit n = 0 makes it edge-sensed.
- R3: The polarity register at 0x40C is read/write. Bit n = 1 selects a high level or a rising edge for pin n, and 0 selects a low level or a falling edge.
- R4: The dual-edge register at 0x408 is read/write. When bit n = 1 and pin n is edge-sensed, both rising and falling edges set the pending bit, whatever the polarity bit holds.
- R5: On an edge-sensed pin, a qualifying edge between two consecutive samples sets raw bit n at 0x414 on that clock edge. The bit then stays set after the input returns.
- R6: Writing to the acknowledge register at 0x41C clears raw bit n where the written bit n is 1, and leaves bits written as 0 unchanged. This register reads 0.
- R7: When a qualifying edge and an acknowledge of the same pin fall in the same cycle, the pending bit ends up set.
- R8: On a level-sensed pin, raw bit n is 1 exactly while the input equals the polarity bit, in the same cycle. Nothing is retained: after the pin returns to edge sensing, its raw bit is 0 until a new edge arrives.
- R9: The interrupt-enable register at 0x410 is read/write. The masked status at 0x418 reads as the raw status ANDed with the enable register.
- R10: `irq_out` is high while any masked status bit is 1. In the cycle after 0 is written to the enable register, `irq_out` is low.
- R11: Addresses not listed above read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | 8 | Synchronized GPIO pin levels |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register byte address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational) |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The assertions assume that `pin_in` is already synchronized to `clk` and changes only between edges. They also assume that `bus_wr`, `bus_addr` and `bus_wdata` are stable around each rising edge. The stimulus drives every input on the falling edge, and reads status half a cycle later. The assertions also rely on the pins being low through reset, so that the reset value of the previous sample shows no false edge. The bench holds all pins at 0 until reset is released.

// File: rtl/gpio_irq_sense_pkg.sv
// Package: shared constants and per-pin configuration type for the GPIO
// interrupt sense unit. Assumes a 12-bit byte address space.
package gpio_irq_sense_pkg;

    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] OFF_SENSE  = 12'h404;
    localparam logic [ADDR_W-1:0] OFF_DUAL   = 12'h408;
    localparam logic [ADDR_W-1:0] OFF_POL    = 12'h40C;
    localparam logic [ADDR_W-1:0] OFF_ENABLE = 12'h410;
    localparam logic [ADDR_W-1:0] OFF_RAW    = 12'h414;
    localparam logic [ADDR_W-1:0] OFF_MASKED = 12'h418;
    localparam logic [ADDR_W-1:0] OFF_ACK    = 12'h41C;

    // Trigger setup of one pin
    typedef struct packed {
        logic level;   // 1 = level sensed, 0 = edge sensed
        logic dual;    // 1 = both edges (edge mode only)
        logic pol;     // 1 = high/rising, 0 = low/falling
    } pin_cfg_t;

endpackage

// File: rtl/gpio_sense_cell.sv
// Module: gpio_sense_cell
// Detects the interrupt condition for one pin. In edge mode it compares the
// current sample with the previous one and latches a sticky pending bit,
// which is cleared by an acknowledge pulse. A new edge wins over a
// simultaneous acknowledge. In level mode the pending bit follows the input
// combinationally, and the sticky latch is held at zero.
// Assumes: pin_i is synchronous to clk; the previous sample resets to 0.
module gpio_sense_cell
    import gpio_irq_sense_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     pin_i,
    input  pin_cfg_t cfg_i,
    input  logic     ack_i,
    output logic     raw_o
);

    logic prev_q;
    logic latch_q;
    logic rise;
    logic fall;
    logic edge_hit;
    logic level_hit;

    // Keep the previous sample for edge comparison
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= pin_i;
    end

    // Classify the transition seen this cycle
    always_comb begin
        rise      = ~prev_q & pin_i;
        fall      = prev_q & ~pin_i;
        if (cfg_i.level)     edge_hit = 1'b0;
        else if (cfg_i.dual) edge_hit = rise | fall;
        else if (cfg_i.pol)  edge_hit = rise;
        else                 edge_hit = fall;
        level_hit = cfg_i.level & (pin_i == cfg_i.pol);
    end

    // Sticky edge status: edge beats acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n)           latch_q <= 1'b0;
        else if (cfg_i.level) latch_q <= 1'b0;
        else if (edge_hit)    latch_q <= 1'b1;
        else if (ack_i)       latch_q <= 1'b0;
    end

    // Select the reported status by mode
    assign raw_o = cfg_i.level ? level_hit : latch_q;

    // R5
    edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_i.level && edge_hit) |=> latch_q);

    // R7
    edge_beats_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_i.level && edge_hit && ack_i) |=> latch_q);

    // R6
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !edge_hit) |=> !latch_q);

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_i.level && !edge_hit && !ack_i) |=> $stable(latch_q));

    // R8
    level_no_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i.level && $past(cfg_i.level)) |-> !latch_q);

endmodule

// File: rtl/gpio_sense_regs.sv
// Module: gpio_sense_regs
// Holds the configuration registers and the enable register. Decodes writes,
// turns acknowledge writes into a one-cycle clear vector, and builds the
// combinational read data.
// Assumes: one write per cycle, and that the byte address selects the register.
module gpio_sense_regs
    import gpio_irq_sense_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [NUM_PINS-1:0] bus_wdata,
    input  logic [NUM_PINS-1:0] raw_i,
    input  logic [NUM_PINS-1:0] masked_i,
    output logic [NUM_PINS-1:0] sense_o,
    output logic [NUM_PINS-1:0] dual_o,
    output logic [NUM_PINS-1:0] pol_o,
    output logic [NUM_PINS-1:0] enable_o,
    output logic [NUM_PINS-1:0] ack_o,
    output logic [NUM_PINS-1:0] bus_rdata
);

    logic [NUM_PINS-1:0] sense_q, dual_q, pol_q, en_q;

    // Configuration and enable register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sense_q <= '0;
            dual_q  <= '0;
            pol_q   <= '0;
            en_q    <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                OFF_SENSE:  sense_q <= bus_wdata;
                OFF_DUAL:   dual_q  <= bus_wdata;
                OFF_POL:    pol_q   <= bus_wdata;
                OFF_ENABLE: en_q    <= bus_wdata;
                default:    ;
            endcase
        end
    end

    // Acknowledge vector, active in the cycle of the write
    assign ack_o = (bus_wr && bus_addr == OFF_ACK) ? bus_wdata : '0;

    // Read multiplexer; the acknowledge register and holes read zero
    always_comb begin
        case (bus_addr)
            OFF_SENSE:  bus_rdata = sense_q;
            OFF_DUAL:   bus_rdata = dual_q;
            OFF_POL:    bus_rdata = pol_q;
            OFF_ENABLE: bus_rdata = en_q;
            OFF_RAW:    bus_rdata = raw_i;
            OFF_MASKED: bus_rdata = masked_i;
            default:    bus_rdata = '0;
        endcase
    end

    assign sense_o  = sense_q;
    assign dual_o   = dual_q;
    assign pol_o    = pol_q;
    assign enable_o = en_q;

endmodule

// File: rtl/gpio_irq_sense.sv
// Module: gpio_irq_sense (top)
// Per-pin GPIO interrupt detection with a register port. It instantiates one
// sense cell per pin, masks the raw status with the enables, and ORs the
// masked bits onto irq_out.
// Assumes: pin_in is already synchronized to clk, and pins are low in reset.
module gpio_irq_sense
    import gpio_irq_sense_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [NUM_PINS-1:0] bus_wdata,
    output logic [NUM_PINS-1:0] bus_rdata,
    output logic                irq_out
);

    logic [NUM_PINS-1:0] sense, dual, pol, enable, ack, raw, masked;

    // Register file and bus decode
    gpio_sense_regs #(.NUM_PINS(NUM_PINS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .raw_i     (raw),
        .masked_i  (masked),
        .sense_o   (sense),
        .dual_o    (dual),
        .pol_o     (pol),
        .enable_o  (enable),
        .ack_o     (ack),
        .bus_rdata (bus_rdata)
    );

    // One detector per pin
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        pin_cfg_t cfg;
        assign cfg = '{level: sense[i], dual: dual[i], pol: pol[i]};
        gpio_sense_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .pin_i (pin_in[i]),
            .cfg_i (cfg),
            .ack_i (ack[i]),
            .raw_o (raw[i])
        );
    end

    // Mask and combine
    assign masked  = raw & enable;
    assign irq_out = |masked;

    // R10
    mask_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_ENABLE && bus_wdata == '0) |=> !irq_out);

endmodule

// File: tb/gpio_irq_sense_tb.sv
module gpio_irq_sense_tb;
    import gpio_irq_sense_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pin_in = '0;
    logic       bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    gpio_irq_sense u_dut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pins(input logic [7:0] v);
        @(negedge clk);
        pin_in = v;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(OFF_SENSE, d);  chk("R1 sense", d, 8'h00);
        rd(OFF_DUAL, d);   chk("R1 dual", d, 8'h00);
        rd(OFF_POL, d);    chk("R1 pol", d, 8'h00);
        rd(OFF_ENABLE, d); chk("R1 enable", d, 8'h00);
        rd(OFF_RAW, d);    chk("R1 raw", d, 8'h00);
        rd(OFF_MASKED, d); chk("R1 masked", d, 8'h00);
        chk("R1 irq", {7'd0, irq_out}, 8'h00);
    endtask

    task automatic t_regs();
        logic [7:0] d;
        wr(OFF_SENSE, 8'hA5);  rd(OFF_SENSE, d);  chk("R2 sense rw", d, 8'hA5);
        wr(OFF_DUAL, 8'h3C);   rd(OFF_DUAL, d);   chk("R4 dual rw", d, 8'h3C);
        wr(OFF_POL, 8'h5A);    rd(OFF_POL, d);    chk("R3 pol rw", d, 8'h5A);
        wr(OFF_ENABLE, 8'hC3); rd(OFF_ENABLE, d); chk("R9 enable rw", d, 8'hC3);
        wr(OFF_ACK, 8'hFF);    rd(OFF_ACK, d);    chk("R6 ack reads 0", d, 8'h00);
        wr(12'h400, 8'hFF);    rd(12'h400, d);    chk("R11 hole", d, 8'h00);
        rd(OFF_SENSE, d); chk("R11 sense untouched", d, 8'hA5);
        wr(OFF_SENSE, 8'h00); wr(OFF_DUAL, 8'h00);
        wr(OFF_POL, 8'h00);   wr(OFF_ENABLE, 8'h00);
    endtask

    task automatic t_edges();
        logic [7:0] d;
        wr(OFF_POL, 8'h01);
        pins(8'h01); rd(OFF_RAW, d); chk("R3 rising pin0", d, 8'h01);
        pins(8'h00); rd(OFF_RAW, d); chk("R5 sticky", d, 8'h01);
        wr(OFF_ACK, 8'h00); rd(OFF_RAW, d); chk("R6 zero write", d, 8'h01);
        wr(OFF_ACK, 8'h01); rd(OFF_RAW, d); chk("R6 clear", d, 8'h00);
        pins(8'h02); rd(OFF_RAW, d); chk("R3 no rise on falling pin", d, 8'h00);
        pins(8'h00); rd(OFF_RAW, d); chk("R3 falling pin1", d, 8'h02);
        wr(OFF_ACK, 8'hFF); wr(OFF_POL, 8'h00);
    endtask

    task automatic t_dual();
        logic [7:0] d;
        wr(OFF_DUAL, 8'h04); wr(OFF_POL, 8'h04);
        pins(8'h04); rd(OFF_RAW, d); chk("R4 rise", d, 8'h04);
        wr(OFF_ACK, 8'h04); rd(OFF_RAW, d); chk("R6 clear dual", d, 8'h00);
        pins(8'h00); rd(OFF_RAW, d); chk("R4 fall ignores pol", d, 8'h04);
        wr(OFF_ACK, 8'hFF); wr(OFF_DUAL, 8'h00); wr(OFF_POL, 8'h00);
    endtask

    task automatic t_level_mask();
        logic [7:0] d;
        wr(OFF_SENSE, 8'h08); wr(OFF_POL, 8'h08);
        @(negedge clk); pin_in = 8'h08; bus_addr = OFF_RAW;
        #1 chk("R8 level same cycle", bus_rdata, 8'h08);
        pins(8'h00); rd(OFF_RAW, d); chk("R8 level drops", d, 8'h00);
        wr(OFF_POL, 8'h00); rd(OFF_RAW, d); chk("R8 low level", d, 8'h08);
        rd(OFF_MASKED, d); chk("R9 masked off", d, 8'h00);
        chk("R10 irq off", {7'd0, irq_out}, 8'h00);
        wr(OFF_ENABLE, 8'h08); rd(OFF_MASKED, d); chk("R9 masked on", d, 8'h08);
        chk("R10 irq on", {7'd0, irq_out}, 8'h01);
        wr(OFF_ENABLE, 8'h00);
        chk("R10 mask all", {7'd0, irq_out}, 8'h00);
        rd(OFF_RAW, d); chk("R9 raw unmasked", d, 8'h08);
        wr(OFF_SENSE, 8'h00); rd(OFF_RAW, d); chk("R8 not latched", d, 8'h00);
    endtask

    task automatic t_collide();
        logic [7:0] d;
        wr(OFF_POL, 8'h10);
        @(negedge clk);
        pin_in = 8'h10; bus_wr = 1'b1; bus_addr = OFF_ACK; bus_wdata = 8'h10;
        @(negedge clk);
        bus_wr = 1'b0;
        rd(OFF_RAW, d); chk("R7 edge wins", d, 8'h10);
        wr(OFF_ENABLE, 8'h10); chk("R10 edge irq", {7'd0, irq_out}, 8'h01);
        wr(OFF_ACK, 8'h10); chk("R6 irq cleared", {7'd0, irq_out}, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_edges();
        t_dual();
        t_level_mask();
        t_collide();
        done = 1;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog got=hung exp=done");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule